// File: doc/BRIEF.md
# Program/Erase Status Responder

This block stands in for the busy window of a memory that programs and erases itself on an internal timer. A command decoder hands it a start request (program or erase), the target address, the new data byte and the byte currently stored there. While the operation runs, the block raises a busy flag and overrides the read data with polling status. When its cycle counter runs out, it issues a one-cycle commit to the storage next to it.

Two polling methods are served. Bit 7 of any read during a program returns the inverse of the bit 7 that was loaded. Bit 6 changes value on every read strobe for as long as the block is busy. Once the operation ends, reads pass the array data through unchanged. Driving the active-low reset input low stops the operation at once, cancels its commit and asks for a high-impedance bus. A start is taken only when the chip is selected and output-enable is high.

Top module: `flash_busy_status`

## Requirements
- R1: While `rst_n` is low, `busy`, `commit_prog` and `commit_erase` are 0 and `out_hiz` is 1.
- R2: An accepted program start raises `busy` on the next clock edge. `busy` then stays high for exactly `PROG_CYCLES` cycles.
- R3: An accepted erase start keeps `busy` high for exactly `ERASE_CYCLES` cycles. `start_prog` wins when both start inputs are high in the same cycle.
- R4: While a program is busy, `rdata[7]` is the inverse of bit 7 of the loaded data. While an erase is busy, `rdata[7]` is 0.
- R5: While busy, `rdata[6]` reads 0 at the first strobe after the start, then takes the opposite value after each `rd_stb` cycle. `rdata[5:0]` follows `array_rdata[5:0]`.
- R6: When not busy, `rdata` equals `array_rdata`, and read strobes no longer change bit 6.
- R7: A start request that arrives while busy is ignored. The running operation keeps its duration, its address and its data.
- R8: A start is ignored when `oe_n` is 0 or `ce_n` is 1 in that cycle.
- R9: The cycle after the last busy cycle of a program, `commit_prog` pulses for one cycle. In that cycle `commit_data` = old data AND new data and `commit_addr` = the loaded address.
- R10: For an erase, the cycle after the last busy cycle has `commit_erase` pulsing with `commit_data` = 8'hFF. The two commit pulses are never high together.
- R11: Taking `rst_n` low during an operation clears `busy` at once. No commit follows, and after release the block is idle in read mode.
- R12: `out_hiz` is 1 whenever `rst_n` is 0, `ce_n` is 1 or `oe_n` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| start_prog | input | 1 | Program start request from the command decoder |
| start_erase | input | 1 | Erase start request from the command decoder |
| cmd_addr | input | AW | Target address of the request |
| cmd_data | input | 8 | New data byte for a program |
| old_data | input | 8 | Byte currently stored at the target address |
| rd_stb | input | 1 | One-cycle host read strobe |
| array_rdata | input | 8 | Array data for the current read address |
| busy | output | 1 | Operation in progress |
| rdata | output | 8 | Read data after status override |
| status_sel | output | 1 | High while rdata carries status |
| out_hiz | output | 1 | Request for a high-impedance data bus |
| commit_prog | output | 1 | One-cycle pulse: write commit_data to the array |
| commit_erase | output | 1 | One-cycle pulse: erase the sector at commit_addr |
| commit_addr | output | AW | Address of the finished operation |
| commit_data | output | 8 | Merged program byte, or 8'hFF for an erase |

## Verification
The assertions check the following on every cycle. An accepted start raises busy on the next edge. The counter is never zero while busy. The latched request holds for the whole busy window. Bit 6 changes after each read strobe inside the window. Every falling edge of busy comes with exactly one commit pulse. Only the bench scenarios can show the rest: that the window lasts exactly the programmed number of cycles, that the merged byte is old AND new, that starts which are inhibited or arrive during a busy window leave no trace, and that an abort in mid-operation cancels the commit.

// File: rtl/flash_busy_status.sv
module flash_busy_status #(
  parameter int AW           = 18,
  parameter int PROG_CYCLES  = 500,
  parameter int ERASE_CYCLES = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic [7:0]    old_data,
  input  logic          rd_stb,
  input  logic [7:0]    array_rdata,
  output logic          busy,
  output logic [7:0]    rdata,
  output logic          status_sel,
  output logic          out_hiz,
  output logic          commit_prog,
  output logic          commit_erase,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, is_prog_q, tog_q, cp_q, cer_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] lat_addr_q;
  logic [7:0]    lat_data_q, lat_old_q;

  wire wr_ok    = !ce_n && oe_n;
  wire go_prog  = start_prog && wr_ok && !busy_q;
  wire go_erase = start_erase && !start_prog && wr_ok && !busy_q;
  wire last     = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      is_prog_q  <= 1'b0;
      tog_q      <= 1'b0;
      cp_q       <= 1'b0;
      cer_q      <= 1'b0;
      cnt_q      <= '0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lat_old_q  <= '0;
    end else begin
      cp_q  <= 1'b0;
      cer_q <= 1'b0;
      if (go_prog || go_erase) begin
        busy_q     <= 1'b1;
        is_prog_q  <= go_prog;
        cnt_q      <= go_prog ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES);
        lat_addr_q <= cmd_addr;
        lat_data_q <= cmd_data;
        lat_old_q  <= old_data;
        tog_q      <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (rd_stb) tog_q <= ~tog_q;
        if (last) begin
          busy_q <= 1'b0;
          cp_q   <= is_prog_q;
          cer_q  <= !is_prog_q;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign status_sel   = busy_q;
  assign rdata        = busy_q ? {is_prog_q & ~lat_data_q[7], tog_q, array_rdata[5:0]} : array_rdata;
  assign out_hiz      = !rst_n || ce_n || oe_n;
  assign commit_prog  = cp_q;
  assign commit_erase = cer_q;
  assign commit_addr  = lat_addr_q;
  assign commit_data  = cp_q ? (lat_old_q & lat_data_q) : 8'hFF;

  AST_START_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog && !ce_n && oe_n && !busy) |=> busy); // R2
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0)); // R2
  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lat_data_q) && $stable(commit_addr))); // R7
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb && !last) |=> (rdata[6] != $past(rdata[6]))); // R5
  AST_FALL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (commit_prog || commit_erase)); // R9
  AST_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_prog, commit_erase})); // R10

endmodule

// File: tb/flash_busy_status_test.sv
module flash_busy_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;
  localparam int E = 30;

  logic clk = 0, rst_n = 0, ce_n = 0, oe_n = 1;
  logic start_prog = 0, start_erase = 0, rd_stb = 0;
  logic [17:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0, old_data = '0, array_rdata = 8'h5A;
  logic busy, status_sel, out_hiz, commit_prog, commit_erase;
  logic [7:0] rdata, commit_data;
  logic [17:0] commit_addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_busy_status #(.AW(18), .PROG_CYCLES(P), .ERASE_CYCLES(E)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .old_data(old_data),
    .rd_stb(rd_stb), .array_rdata(array_rdata),
    .busy(busy), .rdata(rdata), .status_sel(status_sel), .out_hiz(out_hiz),
    .commit_prog(commit_prog), .commit_erase(commit_erase),
    .commit_addr(commit_addr), .commit_data(commit_data));

  // addr[15:0], old[7:0], new[7:0]
  localparam logic [31:0] VEC [4] = '{
    {16'h5555, 8'hFF, 8'hA5}, {16'h1234, 8'hF0, 8'h3C},
    {16'h0002, 8'h81, 8'h7E}, {16'hFFFF, 8'h00, 8'hFF}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit erase, input logic [17:0] a, input logic [7:0] od, input logic [7:0] nd,
                        input int nreads, input bit inject);
    int n;
    bit tog;
    @(negedge clk);
    cmd_addr = a; cmd_data = nd; old_data = od;
    start_prog = !erase; start_erase = erase;
    @(negedge clk);
    start_prog = 0; start_erase = 0;
    chk(busy === 1'b1, erase ? "R3 busy rise" : "R2 busy rise", busy, 1);
    n = 0; tog = 0;
    while (busy === 1'b1 && n < 1000) begin
      if (inject && n == 3) begin
        start_prog = 1; cmd_addr = 18'h3; cmd_data = 8'h00; old_data = 8'h00;
      end
      if (n < nreads) begin
        rd_stb = 1; #1;
        chk(rdata[7] === (erase ? 1'b0 : ~nd[7]), "R4 poll bit7", rdata, {erase ? 1'b0 : ~nd[7]});
        chk(rdata[6] === tog, "R5 toggle bit6", rdata[6], tog);
        chk(rdata[5:0] === array_rdata[5:0], "R5 low bits", rdata, array_rdata);
        tog = ~tog;
      end
      @(negedge clk);
      rd_stb = 0; start_prog = 0;
      n++;
    end
    chk(n == (erase ? E : P), erase ? "R3 duration" : (inject ? "R7 duration" : "R2 duration"), n, erase ? E : P);
    if (erase) begin
      chk(commit_erase === 1'b1 && commit_prog === 1'b0, "R10 erase commit", {commit_prog, commit_erase}, 2'b01);
      chk(commit_data === 8'hFF && commit_addr === a, "R10 erase data", commit_data, 8'hFF);
    end else begin
      chk(commit_prog === 1'b1 && commit_erase === 1'b0, "R9 prog commit", {commit_prog, commit_erase}, 2'b10);
      chk(commit_data === (od & nd), inject ? "R7 data kept" : "R9 merged data", commit_data, od & nd);
      chk(commit_addr === a, inject ? "R7 addr kept" : "R9 addr", commit_addr, a);
    end
    @(negedge clk);
    chk(commit_prog === 1'b0 && commit_erase === 1'b0, "R9 single pulse", {commit_prog, commit_erase}, 0);
    rd_stb = 1; #1;
    chk(rdata === array_rdata, "R6 true data", rdata, array_rdata);
    @(negedge clk); #1;
    chk(rdata === array_rdata && busy === 1'b0, "R6 toggle stopped", rdata, array_rdata);
    rd_stb = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(busy === 1'b0 && commit_prog === 1'b0 && commit_erase === 1'b0, "R1 reset outputs", busy, 0);
    chk(out_hiz === 1'b1, "R1 hiz in reset", out_hiz, 1);
    @(negedge clk); rst_n = 1;

    foreach (VEC[i]) run_op(0, {2'b00, VEC[i][31:16]}, VEC[i][15:8], VEC[i][7:0], 4, 0);

    run_op(1, 18'h20000, 8'h00, 8'h00, 3, 0);
    run_op(0, 18'h00123, 8'hCC, 8'hAA, 2, 1);

    @(negedge clk);
    start_erase = 1; start_prog = 1; cmd_addr = 18'h77; cmd_data = 8'h0F; old_data = 8'hFF;
    @(negedge clk); start_erase = 0; start_prog = 0;
    repeat (P) @(negedge clk);
    chk(commit_prog === 1'b1 && commit_erase === 1'b0, "R3 prog priority", {commit_prog, commit_erase}, 2'b10);
    repeat (2) @(negedge clk);

    oe_n = 0; start_prog = 1;
    @(negedge clk); start_prog = 0;
    chk(busy === 1'b0, "R8 oe_n low inhibits", busy, 0);
    oe_n = 1; ce_n = 1; start_erase = 1;
    @(negedge clk); start_erase = 0;
    chk(busy === 1'b0, "R8 ce_n high inhibits", busy, 0);
    ce_n = 0;

    start_prog = 1; cmd_data = 8'h00;
    @(negedge clk); start_prog = 0;
    repeat (3) @(negedge clk);
    rst_n = 0; #1;
    chk(busy === 1'b0 && out_hiz === 1'b1, "R11 abort clears busy", {busy, out_hiz}, 2'b01);
    @(negedge clk); rst_n = 1;
    begin
      bit seen = 0;
      for (int k = 0; k < P + 3; k++) begin
        @(negedge clk);
        if (commit_prog || commit_erase || busy) seen = 1;
      end
      chk(!seen, "R11 no commit after abort", seen, 0);
    end
    #1;
    chk(rdata === array_rdata, "R11 read mode", rdata, array_rdata);

    ce_n = 0; oe_n = 0; #1;
    chk(out_hiz === 1'b0, "R12 driven", out_hiz, 0);
    oe_n = 1; #1;
    chk(out_hiz === 1'b1, "R12 oe high", out_hiz, 1);
    oe_n = 0; ce_n = 1; #1;
    chk(out_hiz === 1'b1, "R12 ce high", out_hiz, 1);
    ce_n = 0; oe_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule